// File: doc/BRIEF.md
# Interrupt Destination Bitmask Generator

This block decides which processor agents, out of a parameterised population (32 by default), receive an interrupt message. Each request carries the following fields:

- an 8-bit destination;
- a physical or logical addressing bit;
- a 2-bit shorthand;
- the index of the sending agent;
- a 3-bit delivery mode;
- trigger and level bits.

Each agent slot reports four things:

- whether the slot is populated;
- its physical ID;
- its 8-bit logical ID;
- its 4-bit logical format code.

The block matches every agent in parallel and applies the shorthand. For lowest-priority delivery it reduces the set to one agent. The result is registered.

A request is a single-cycle strobe. One clock later the block presents the delivery bitmask with a one-cycle valid pulse. It also presents the delivery mode and a flag that marks an arbitration-resync message. The mask, mode and flag stay on the outputs until the next request. Carrying the message to the agents, and deciding whether an agent accepts it, belong to other blocks.

Top module: `irq_dest_mask`

## Requirements
- R1: In physical mode with shorthand 0, a destination of 0xFF selects every populated agent.
- R2: In physical mode with shorthand 0 and any other destination, the mask holds only the lowest-indexed populated agent whose physical ID equals the destination. It is all zeros if no agent matches.
- R3: In logical mode, an agent with format 0xF matches when the destination AND its logical ID is nonzero.
- R4: In logical mode, an agent with format 0x0 matches under two conditions: bits 7:4 of the destination equal bits 7:4 of its logical ID, and bits 3:0 of the two have at least one set bit in common.
- R5: An agent whose format is neither 0x0 nor 0xF never matches in logical mode. An unpopulated agent is never set in the mask, whatever the mode or shorthand.
- R6: Shorthand 1 selects only the sender. Shorthand 2 selects all populated agents. Shorthand 3 selects all populated agents except the sender. For shorthands 1 to 3 the destination and the addressing bit are ignored.
- R7: With delivery mode 1 (lowest priority), the mask is reduced to its lowest-numbered set bit. An empty set stays empty. Any other mode keeps the full set.
- R8: The resync flag is 1 only when the delivery mode is 5, level is 0 and trigger is 1. In that case the mask names the agents whose arbitration IDs are to be reloaded.
- R9: The valid output is high exactly in the cycle after a request strobe. The mask, mode and flag change only in that cycle and are held between requests.
- R10: After reset, valid, mask, mode and flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per message |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| req_sender | input | 5 | Index of the sending agent |
| req_mode | input | 3 | Delivery mode |
| req_trigger | input | 1 | Trigger bit (1 = level) |
| req_level | input | 1 | Level bit |
| agent_present | input | 32 | Populated-slot mask |
| agent_phys_id | input | 256 | Physical IDs, agent i at bits 8i+7:8i |
| agent_log_id | input | 256 | Logical IDs, agent i at bits 8i+7:8i |
| agent_fmt | input | 128 | Format codes, agent i at bits 4i+3:4i |
| out_valid | output | 1 | One-cycle result strobe |
| out_mask | output | 32 | Delivery bitmask, bit i = agent i |
| out_mode | output | 3 | Delivery mode of the last request |
| out_arb_sync | output | 1 | Last request was an arbitration resync |

## Verification
Every output is one register behind the request, so any wrong match term, shorthand decode or reduction shows up in the mask on the cycle after the strobe. Nothing is accumulated between requests, so one faulty compare cannot hide: it corrupts exactly the requests that address that agent or format. A broken hold path shows up one cycle later, as a mask or mode that moves while valid is low. The bench mixes random agent tables, including duplicate physical IDs and illegal formats, with directed broadcast, self and empty-set cases.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
    localparam logic [2:0] MODE_LOWPRI = 3'd1;
    localparam logic [2:0] MODE_INIT   = 3'd5;
    localparam logic [3:0] FMT_CLUSTER = 4'h0;
    localparam logic [3:0] FMT_FLAT    = 4'hF;

    typedef enum logic [1:0] {
        SH_FIELD    = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL      = 2'd2,
        SH_ALL_BUT  = 2'd3
    } shorthand_e;
endpackage

// File: rtl/irq_agent_match.sv
module irq_agent_match
    import irq_dest_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int FMT_W = 4
) (
    input  logic [ID_W-1:0]  dest,
    input  logic             present,
    input  logic [ID_W-1:0]  phys_id,
    input  logic [ID_W-1:0]  log_id,
    input  logic [FMT_W-1:0] fmt,
    output logic             hit_phys,
    output logic             hit_log
);
    localparam int HALF = ID_W / 2;

    logic grp_eq;
    logic mem_any;

    always_comb begin
        grp_eq   = (dest[ID_W-1:HALF] == log_id[ID_W-1:HALF]);
        mem_any  = |(dest[HALF-1:0] & log_id[HALF-1:0]);
        hit_phys = present && (phys_id == dest);
        if (fmt == FMT_W'(FMT_FLAT)) begin
            hit_log = present && (|(dest & log_id));
        end else if (fmt == FMT_W'(FMT_CLUSTER)) begin
            hit_log = present && grp_eq && mem_any;
        end else begin
            hit_log = 1'b0;
        end
    end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec_in,
    output logic [W-1:0] vec_out
);
    always_comb begin
        vec_out = vec_in & (~vec_in + W'(1));
    end
endmodule

// File: rtl/irq_dest_mask.sv
module irq_dest_mask
    import irq_dest_pkg::*;
#(
    parameter int N_AGENTS = 32,
    parameter int ID_W     = 8,
    parameter int FMT_W    = 4,
    parameter int IDX_W    = $clog2(N_AGENTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ID_W-1:0]           req_dest,
    input  logic                      req_logical,
    input  logic [1:0]                req_shorthand,
    input  logic [IDX_W-1:0]          req_sender,
    input  logic [2:0]                req_mode,
    input  logic                      req_trigger,
    input  logic                      req_level,
    input  logic [N_AGENTS-1:0]       agent_present,
    input  logic [N_AGENTS*ID_W-1:0]  agent_phys_id,
    input  logic [N_AGENTS*ID_W-1:0]  agent_log_id,
    input  logic [N_AGENTS*FMT_W-1:0] agent_fmt,
    output logic                      out_valid,
    output logic [N_AGENTS-1:0]       out_mask,
    output logic [2:0]                out_mode,
    output logic                      out_arb_sync
);
    localparam logic [ID_W-1:0]     BCAST_ID = {ID_W{1'b1}};
    localparam logic [N_AGENTS-1:0] ONE_HOT0 = N_AGENTS'(1);

    typedef struct packed {
        logic                valid;
        logic [N_AGENTS-1:0] mask;
        logic [2:0]          mode;
        logic                arb_sync;
    } result_t;

    result_t res_d, res_q;

    logic [N_AGENTS-1:0] phys_hits;
    logic [N_AGENTS-1:0] log_hits;
    logic [N_AGENTS-1:0] phys_first;
    logic [N_AGENTS-1:0] target;
    logic [N_AGENTS-1:0] target_first;

    for (genvar gi = 0; gi < N_AGENTS; gi++) begin : g_agent
        irq_agent_match #(
            .ID_W  (ID_W),
            .FMT_W (FMT_W)
        ) u_match (
            .dest     (req_dest),
            .present  (agent_present[gi]),
            .phys_id  (agent_phys_id[gi*ID_W +: ID_W]),
            .log_id   (agent_log_id[gi*ID_W +: ID_W]),
            .fmt      (agent_fmt[gi*FMT_W +: FMT_W]),
            .hit_phys (phys_hits[gi]),
            .hit_log  (log_hits[gi])
        );
    end

    irq_lowest_pick #(.W(N_AGENTS)) u_phys_first (
        .vec_in  (phys_hits),
        .vec_out (phys_first)
    );

    irq_lowest_pick #(.W(N_AGENTS)) u_lowpri (
        .vec_in  (target),
        .vec_out (target_first)
    );

    always_comb begin
        logic [N_AGENTS-1:0] self_oh;
        logic [N_AGENTS-1:0] field_sel;
        self_oh = ONE_HOT0 << req_sender;
        if (req_logical) begin
            field_sel = log_hits;
        end else if (req_dest == BCAST_ID) begin
            field_sel = agent_present;
        end else begin
            field_sel = phys_first;
        end
        case (shorthand_e'(req_shorthand))
            SH_SELF:    target = self_oh & agent_present;
            SH_ALL:     target = agent_present;
            SH_ALL_BUT: target = agent_present & ~self_oh;
            default:    target = field_sel;
        endcase
    end

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (req_valid) begin
            res_d.valid    = 1'b1;
            res_d.mode     = req_mode;
            res_d.mask     = (req_mode == MODE_LOWPRI) ? target_first : target;
            res_d.arb_sync = (req_mode == MODE_INIT) && !req_level && req_trigger;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.valid;
    assign out_mask     = res_q.mask;
    assign out_mode     = res_q.mode;
    assign out_arb_sync = res_q.arb_sync;
endmodule

// File: rtl/irq_dest_mask_chk.sv
module irq_dest_mask_chk #(
    parameter int N_AGENTS = 32,
    parameter int IDX_W    = $clog2(N_AGENTS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [1:0]          req_shorthand,
    input logic [IDX_W-1:0]    req_sender,
    input logic [2:0]          req_mode,
    input logic [N_AGENTS-1:0] agent_present,
    input logic                out_valid,
    input logic [N_AGENTS-1:0] out_mask,
    input logic [2:0]          out_mode,
    input logic                out_arb_sync
);
    p_valid_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_mask) && $stable(out_mode) && $stable(out_arb_sync)));
    p_lowpri_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 3'd1) |-> $onehot0(out_mask));
    p_only_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((out_mask & ~$past(agent_present)) == '0));
    p_all_but_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_shorthand == 2'd3) |=> !out_mask[$past(req_sender)]);
    p_self_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_shorthand == 2'd1) |=> ($countones(out_mask) <= 1));
    p_resync_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_arb_sync) |-> (out_mode == 3'd5));
endmodule

bind irq_dest_mask irq_dest_mask_chk #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_shorthand (req_shorthand),
    .req_sender    (req_sender),
    .req_mode      (req_mode),
    .agent_present (agent_present),
    .out_valid     (out_valid),
    .out_mask      (out_mask),
    .out_mode      (out_mode),
    .out_arb_sync  (out_arb_sync)
);

// File: tb/tb_irq_dest_mask.sv
module tb_irq_dest_mask;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [7:0]   req_dest = '0;
    logic         req_logical = 1'b0;
    logic [1:0]   req_shorthand = '0;
    logic [4:0]   req_sender = '0;
    logic [2:0]   req_mode = '0;
    logic         req_trigger = 1'b0;
    logic         req_level = 1'b0;
    logic [N-1:0]   agent_present = '0;
    logic [N*8-1:0] agent_phys_id = '0;
    logic [N*8-1:0] agent_log_id = '0;
    logic [N*4-1:0] agent_fmt = '0;
    logic         out_valid;
    logic [N-1:0] out_mask;
    logic [2:0]   out_mode;
    logic         out_arb_sync;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_dest_mask dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .req_logical(req_logical), .req_shorthand(req_shorthand),
        .req_sender(req_sender), .req_mode(req_mode), .req_trigger(req_trigger),
        .req_level(req_level), .agent_present(agent_present),
        .agent_phys_id(agent_phys_id), .agent_log_id(agent_log_id),
        .agent_fmt(agent_fmt), .out_valid(out_valid), .out_mask(out_mask),
        .out_mode(out_mode), .out_arb_sync(out_arb_sync)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_mask();
        logic [N-1:0] m;
        logic [N-1:0] r;
        bit found;
        m = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            logic [7:0] pid;
            logic [7:0] lid;
            logic [3:0] f;
            bit hit;
            pid = agent_phys_id[i*8 +: 8];
            lid = agent_log_id[i*8 +: 8];
            f   = agent_fmt[i*4 +: 4];
            hit = 1'b0;
            case (req_shorthand)
                2'd1: hit = (i == int'(req_sender));
                2'd2: hit = 1'b1;
                2'd3: hit = (i != int'(req_sender));
                default: begin
                    if (!req_logical) begin
                        if (req_dest == 8'hFF) hit = 1'b1;
                        else if (!found && pid == req_dest) begin
                            hit = 1'b1;
                            found = agent_present[i];
                        end
                    end else if (f == 4'hF) begin
                        hit = (req_dest & lid) != 0;
                    end else if (f == 4'h0) begin
                        hit = (req_dest[7:4] == lid[7:4]) && ((req_dest[3:0] & lid[3:0]) != 0);
                    end
                end
            endcase
            m[i] = hit && agent_present[i];
        end
        if (req_mode == 3'd1) begin
            r = '0;
            for (int i = N - 1; i >= 0; i--) if (m[i]) r = '0 | (32'd1 << i);
            m = r;
        end
        return m;
    endfunction

    task automatic send_and_check(input string tag);
        logic [N-1:0] exp_m;
        logic exp_sync;
        @(negedge clk);
        req_valid = 1'b1;
        exp_m = model_mask();
        exp_sync = (req_mode == 3'd5) && !req_level && req_trigger;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R9 valid"}, {31'd0, out_valid}, 32'd1);
        chk(tag, out_mask, exp_m);
        chk({tag, " R8 sync"}, {31'd0, out_arb_sync}, {31'd0, exp_sync});
        req_dest = ~req_dest;
        req_shorthand = req_shorthand + 2'd1;
        req_mode = req_mode + 3'd1;
        @(negedge clk);
        chk({tag, " R9 valid low"}, {31'd0, out_valid}, 32'd0);
        chk({tag, " R9 hold mask"}, out_mask, exp_m);
    endtask

    task automatic set_req(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                           input logic [4:0] s, input logic [2:0] md,
                           input logic tr, input logic lv);
        req_dest = d; req_logical = lg; req_shorthand = sh; req_sender = s;
        req_mode = md; req_trigger = tr; req_level = lv;
    endtask

    task automatic random_agents();
        agent_present = $urandom;
        for (int i = 0; i < N; i++) begin
            int k;
            agent_phys_id[i*8 +: 8] = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 7)) : 8'(i);
            agent_log_id[i*8 +: 8]  = 8'($urandom);
            k = $urandom_range(0, 4);
            agent_fmt[i*4 +: 4] = (k < 2) ? 4'hF : (k < 4) ? 4'h0 : 4'($urandom_range(1, 14));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            agent_phys_id[i*8 +: 8] = 8'(i);
            agent_log_id[i*8 +: 8]  = 8'h11 << (i % 4);
            agent_fmt[i*4 +: 4]     = 4'hF;
        end
        agent_present = 32'h0000_FFFF;
        repeat (3) @(negedge clk);
        chk("R10 valid", {31'd0, out_valid}, 32'd0);
        chk("R10 mask", out_mask, 32'd0);
        chk("R10 mode", {29'd0, out_mode}, 32'd0);
        chk("R10 sync", {31'd0, out_arb_sync}, 32'd0);
        rst_n = 1'b1;

        set_req(8'hFF, 1'b0, 2'd0, 5'd0, 3'd0, 1'b0, 1'b0);
        send_and_check("R1 broadcast");
        set_req(8'h05, 1'b0, 2'd0, 5'd0, 3'd0, 1'b0, 1'b0);
        send_and_check("R2 unicast");
        set_req(8'h14, 1'b0, 2'd0, 5'd0, 3'd0, 1'b0, 1'b0);
        send_and_check("R2 absent id");
        agent_phys_id[9*8 +: 8] = 8'h03;
        agent_phys_id[12*8 +: 8] = 8'h03;
        agent_present[3] = 1'b0;
        set_req(8'h03, 1'b0, 2'd0, 5'd0, 3'd0, 1'b0, 1'b0);
        send_and_check("R2 duplicate id");
        set_req(8'h22, 1'b1, 2'd0, 5'd0, 3'd0, 1'b0, 1'b0);
        send_and_check("R3 flat");
        for (int i = 0; i < N; i++) agent_fmt[i*4 +: 4] = 4'h0;
        agent_log_id[2*8 +: 8] = 8'h36;
        agent_log_id[4*8 +: 8] = 8'h31;
        agent_log_id[6*8 +: 8] = 8'h26;
        set_req(8'h34, 1'b1, 2'd0, 5'd0, 3'd0, 1'b0, 1'b0);
        send_and_check("R4 cluster");
        agent_fmt[2*4 +: 4] = 4'h7;
        set_req(8'h34, 1'b1, 2'd0, 5'd0, 3'd0, 1'b0, 1'b0);
        send_and_check("R5 bad format");
        set_req(8'h00, 1'b0, 2'd1, 5'd7, 3'd0, 1'b0, 1'b0);
        send_and_check("R6 self");
        set_req(8'h00, 1'b0, 2'd1, 5'd20, 3'd0, 1'b0, 1'b0);
        send_and_check("R5 self unpopulated");
        set_req(8'h00, 1'b1, 2'd2, 5'd7, 3'd0, 1'b0, 1'b0);
        send_and_check("R6 all");
        set_req(8'h00, 1'b0, 2'd3, 5'd7, 3'd0, 1'b0, 1'b0);
        send_and_check("R6 all but self");
        set_req(8'hFF, 1'b0, 2'd0, 5'd0, 3'd1, 1'b0, 1'b0);
        send_and_check("R7 lowpri");
        set_req(8'h80, 1'b1, 2'd0, 5'd0, 3'd1, 1'b0, 1'b0);
        send_and_check("R7 lowpri empty");
        set_req(8'hFF, 1'b0, 2'd2, 5'd0, 3'd5, 1'b1, 1'b0);
        send_and_check("R8 resync");
        set_req(8'hFF, 1'b0, 2'd2, 5'd0, 3'd5, 1'b1, 1'b1);
        send_and_check("R8 init assert");

        for (int n = 0; n < 400; n++) begin
            if (n % 8 == 0) random_agents();
            set_req(($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom), 1'($urandom),
                    ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd0, 5'($urandom),
                    3'($urandom), 1'($urandom), 1'($urandom));
            send_and_check("R3 R4 R7 random");
            if (req_valid === 1'b0) chk("R9 mode", {29'd0, out_mode}, {29'd0, 3'(req_mode - 3'd1)});
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule